// File: doc/BRIEF.md
# Recirculating Character Display Store

This block keeps one screen of text in loops of shift registers rather than in addressable RAM. There is one loop, or track, for each bit of a character. Every track holds one bit of every screen position. All tracks step together on a single shared shift enable, so the bits of any one character stay lined up. The character at the head of the loops is the tap. On each step the tap is fed back to the tail unchanged, unless a write replaces it on that step. The loops therefore circulate without losing data.

The tap character is offered to a character-generator consumer as a valid/ready stream. While `disp_valid` is high and `disp_ready` is low, the store stalls. During a stall the tap character and its position hold steady. `disp_valid` never falls while a character is waiting. It falls only after a transfer on which a scroll request was taken. After that transfer the store steps on for one text row (COLS positions) with `disp_valid` low, whatever `disp_ready` does. The consumer therefore sees its frame start one row further down the circulating screen.

`tap_pos` reports which screen location is at the tap. Software writes a location by asserting `wr_en` with a character on a step where that location passes the tap. Each track is a chain of fixed-length segments, and SEG_LEN must divide ROWS*COLS.

Top module: `circ_text_store`

## Requirements
- R1: After reset, every location holds the blank code (parameter BLANK, default 0x20), `tap_pos` and `start_pos` are 0, and `disp_valid` is 1.
- R2: A step occurs on a cycle where `disp_ready` is high or a row gap is in progress. On each step, `tap_pos` advances by one modulo ROWS*COLS. A location's character returns unchanged to the tap ROWS*COLS steps later.
- R3: While `disp_valid` is 1 and `disp_ready` is 0, the next cycle shows the same `disp_char` and `tap_pos`, and `disp_valid` is still 1.
- R4: When `wr_en` is high on a step, `wr_data` replaces the character at the location then at the tap, in all BITS tracks. `disp_char` on that cycle still shows the old character.
- R5: On a cycle with no step, `wr_en` has no effect on any location.
- R6: On a transfer cycle (`disp_valid` and `disp_ready` both 1), `scroll_req` is taken. The next COLS cycles are gap steps with `disp_valid` low, and each advances `tap_pos`. `start_pos` moves forward by COLS modulo ROWS*COLS.
- R7: A `scroll_req` during a row gap, or on a stalled cycle, is ignored: `start_pos` and the gap length are unchanged.
- R8: `disp_sof` is 1 exactly when `tap_pos` equals `start_pos`.
- R9: Writes on gap steps take effect just as on transfer steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | output | 1 | Tap character offered to the consumer |
| disp_ready | input | 1 | Consumer accepts the character |
| disp_char | output | BITS | Character at the tap |
| disp_sof | output | 1 | Tap is at the first location of the displayed frame |
| tap_pos | output | clog2(ROWS*COLS) | Location currently at the tap |
| start_pos | output | clog2(ROWS*COLS) | Location shown first in the frame |
| scroll_req | input | 1 | Request a one-row scroll |
| wr_en | input | 1 | Replace the tap character on this step |
| wr_data | input | BITS | Character to write |

## Verification
Some properties are checked by assertions on every cycle. A stalled tap holds its value, position and valid. A step with no write feeds the old tap bit back into each track's tail, and a write loads the written bit there instead. A fall of `disp_valid` can only follow a transfer that carried a scroll request, and the gap counter never exceeds one row. Other behaviour needs the bench's scenarios to show it. These are the full-circle return of written data and the blank screen after reset. They also include the exact row-gap length, the ignored requests and writes, the writes made inside a gap, and the frame-start marker moving by one row per scroll.

// File: rtl/circ_pkg.sv
package circ_pkg;
  // Advance a ring index by step positions, modulo n.
  function automatic int unsigned ring_add(int unsigned v, int unsigned step, int unsigned n);
    return (v + step) % n;
  endfunction
endpackage

// File: rtl/circ_seg.sv
module circ_seg #(
  parameter int LEN  = 200,
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout,
  output logic tail_q
);
  logic [LEN-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= {LEN{INIT}};
    else if (en) q <= {din, q[LEN-1:1]};
  end

  assign dout   = q[0];
  assign tail_q = q[LEN-1];
endmodule

// File: rtl/circ_track.sv
module circ_track #(
  parameter int SEG_LEN = 200,
  parameter int SEGS    = 9,
  parameter bit INIT    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wr,
  input  logic wbit,
  output logic tap
);
  logic [SEGS:0]   link;
  logic [SEGS-1:0] tails;

  // Feedback: the tap re-enters the tail unless a write overrides it.
  assign link[SEGS] = wr ? wbit : link[0];
  assign tap        = link[0];

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    circ_seg #(.LEN(SEG_LEN), .INIT(INIT)) u_seg (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .din    (link[s+1]),
      .dout   (link[s]),
      .tail_q (tails[s])
    );
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tap));
  p_recirc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr) |=> tails[SEGS-1] == $past(tap));
  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr) |=> tails[SEGS-1] == $past(wbit));
endmodule

// File: rtl/circ_pace.sv
module circ_pace
  import circ_pkg::*;
#(
  parameter int ROWS = 25,
  parameter int COLS = 72,
  localparam int N   = ROWS * COLS,
  localparam int PW  = $clog2(N),
  localparam int GW  = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_ready,
  input  logic          scroll_req,
  output logic          fire,
  output logic          shown,
  output logic          sof,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] start
);
  logic [GW-1:0] gap;
  logic          in_gap, take;

  assign in_gap = (gap != '0);
  assign shown  = !in_gap;
  assign fire   = disp_ready || in_gap;
  assign take   = disp_ready && !in_gap && scroll_req;
  assign sof    = (pos == start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      start <= '0;
      gap   <= '0;
    end else if (fire) begin
      pos <= PW'(ring_add(int'(pos), 1, N));
      if (take) begin
        gap   <= GW'(COLS);
        start <= PW'(ring_add(int'(start), COLS, N));
      end else if (in_gap) begin
        gap <= gap - 1'b1;
      end
    end
  end

  p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap) <= COLS);
  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |=> $stable(start));
endmodule

// File: rtl/circ_text_store.sv
module circ_text_store #(
  parameter int ROWS    = 25,
  parameter int COLS    = 72,
  parameter int BITS    = 6,
  parameter int SEG_LEN = 200,
  parameter int BLANK   = 32,
  localparam int N      = ROWS * COLS,
  localparam int PW     = $clog2(N),
  localparam int SEGS   = N / SEG_LEN
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            disp_valid,
  input  logic            disp_ready,
  output logic [BITS-1:0] disp_char,
  output logic            disp_sof,
  output logic [PW-1:0]   tap_pos,
  output logic [PW-1:0]   start_pos,
  input  logic            scroll_req,
  input  logic            wr_en,
  input  logic [BITS-1:0] wr_data
);
  localparam logic [BITS-1:0] BLANK_V = BITS'(BLANK);

  logic fire;

  circ_pace #(.ROWS(ROWS), .COLS(COLS)) u_pace (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_ready (disp_ready),
    .scroll_req (scroll_req),
    .fire       (fire),
    .shown      (disp_valid),
    .sof        (disp_sof),
    .pos        (tap_pos),
    .start      (start_pos)
  );

  for (genvar b = 0; b < BITS; b++) begin : g_track
    circ_track #(.SEG_LEN(SEG_LEN), .SEGS(SEGS), .INIT(BLANK_V[b])) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (fire),
      .wr    (wr_en),
      .wbit  (wr_data[b]),
      .tap   (disp_char[b])
    );
  end

  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=>
      disp_valid && $stable(disp_char) && $stable(tap_pos));
  p_gap_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_valid) |-> $past(disp_ready) && $past(scroll_req));
endmodule

// File: tb/circ_text_store_tb.sv
module circ_text_store_tb;
  localparam int ROWS = 4, COLS = 8, BITS = 6, SEG_LEN = 8, BLANK = 32;
  localparam int N = ROWS * COLS;
  localparam int PW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic disp_valid, disp_ready = 0, disp_sof;
  logic [BITS-1:0] disp_char, wr_data = '0;
  logic [PW-1:0] tap_pos, start_pos;
  logic scroll_req = 0, wr_en = 0;

  always #2 clk = ~clk;

  circ_text_store #(.ROWS(ROWS), .COLS(COLS), .BITS(BITS), .SEG_LEN(SEG_LEN), .BLANK(BLANK)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_char(disp_char), .disp_sof(disp_sof), .tap_pos(tap_pos), .start_pos(start_pos),
    .scroll_req(scroll_req), .wr_en(wr_en), .wr_data(wr_data));

  int n_chk = 0, n_fail = 0;
  logic [BITS-1:0] mem [N];
  int m_pos = 0, m_start = 0, m_gap = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle, compare outputs with the model, then advance the model.
  task automatic step(logic rdy, logic scr, logic we, logic [BITS-1:0] wd, string tag);
    bit fire;
    @(negedge clk);
    disp_ready = rdy; scroll_req = scr; wr_en = we; wr_data = wd;
    #1;
    chk({tag, " valid"}, int'(disp_valid), int'(m_gap == 0));
    chk({tag, " char"}, int'(disp_char), int'(mem[m_pos]));
    chk("R2 tap_pos", int'(tap_pos), m_pos);
    chk("R6 start_pos", int'(start_pos), m_start);
    chk("R8 sof", int'(disp_sof), int'(m_pos == m_start));
    fire = rdy || (m_gap != 0);
    if (fire) begin
      if (we) mem[m_pos] = wd;
      m_pos = (m_pos + 1) % N;
      if (rdy && m_gap == 0 && scr) begin
        m_gap = COLS;
        m_start = (m_start + COLS) % N;
      end else if (m_gap != 0) m_gap--;
    end
    @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 valid", int'(disp_valid), 1);
    chk("R1 tap_pos", int'(tap_pos), 0);
    chk("R1 start_pos", int'(start_pos), 0);
    for (int i = 0; i < N; i++) step(1, 0, 0, '0, "R1");
  endtask

  task automatic t_fill();
    for (int i = 0; i < N; i++) step(1, 0, 1, BITS'(i * 5 + 3), "R4");
    for (int i = 0; i < N; i++) step(1, 0, 0, '0, "R2");
  endtask

  task automatic t_stall();
    for (int i = 0; i < 5; i++) step(0, 1, 1, 6'h3f, "R3");
    for (int i = 0; i < N + 1; i++) step(1, 0, 0, '0, "R5");
  endtask

  task automatic t_scroll();
    step(1, 1, 0, '0, "R6");
    for (int i = 0; i < COLS; i++) step(0, 0, 0, '0, "R6");
    step(0, 0, 0, '0, "R6");
    for (int i = 0; i < N; i++) step(1, 0, 0, '0, "R8");
  endtask

  task automatic t_scroll_ignored();
    step(1, 1, 0, '0, "R7");
    for (int i = 0; i < COLS; i++) step(i[0], 1, 0, '0, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, "R7");
  endtask

  task automatic t_gap_write();
    step(1, 1, 0, '0, "R9");
    for (int i = 0; i < COLS; i++) step(0, 0, 1, BITS'(40 + i), "R9");
    for (int i = 0; i < N; i++) step(1, 0, 0, '0, "R9");
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < N; i++) mem[i] = BITS'(BLANK);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_fill();
    t_stall();
    t_scroll();
    t_scroll_ignored();
    t_gap_write();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule